// File: doc/BRIEF.md
# Dual-Mode Manchester Line Encoder with Cell Checker

This block turns a stream of single data bits into a two-phase line code. Each bit occupies one cell of two clock cycles, because the block runs on a clock at twice the bit rate. Every cell carries a level change at its middle.

A mode input selects one of two codes:
- **Plain mode:** the direction of the mid-cell change is fixed by the bit value.
- **Differential mode:** the bit value says whether the mid-cell change repeats the direction of the previous cell's change or reverses it.

When no bit is offered, the line rests at a parameter-defined idle level. A marker output flags the first half of every cell, so downstream logic can find the cell boundaries.

Bits enter through a valid/ready handshake:
- A bit transfers on a rising clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is low during the first half of a cell. It is high during the second half and while the line is idle, so a continuous stream produces back-to-back cells with no gap.
- A source that sees `in_ready` low must hold `in_bit` and `mode_diff` steady until the transfer.

A separate checker path receives a line and a first-half marker. It compares the two halves of each cell, reports the first-half level, and raises a violation flag for a cell with no mid-cell change.

Top module: `manchester_line_enc`

## Requirements
- R1: In plain mode (`mode_diff`=0), a bit of value 1 drives the line high in the first half-cell and low in the second half-cell.
- R2: In plain mode, a bit of value 0 drives the line low in the first half-cell and high in the second half-cell.
- R3: In differential mode (`mode_diff`=1), a bit of value 1 makes the mid-cell change run opposite to the previous cell's mid-cell change. A bit of value 0 makes it run in the same direction.
- R4: The direction of the most recent mid-cell change is updated in every cell, in either mode. After reset it reads as falling (high-to-low).
- R5: `in_ready` is high while the line is idle and during the second half-cell, and low during the first half-cell. A transfer at a rising edge starts a new cell at that edge.
- R6: The mode is sampled only at the transfer. A change of `mode_diff` inside a cell leaves that cell's line levels unchanged.
- R7: `cell_start` is 1 exactly during the first half-cell and 0 otherwise.
- R8: If no transfer happens at the end of a cell, the line returns to `IDLE_LEVEL` and stays there until the next transfer.
- R9: The checker samples `rx_line` at an edge where `rx_first` is 1 and again at the following edge. It then pulses `rx_done` for one cycle and sets `rx_bit` to the first sample. It sets `rx_viol` to 1 when the two samples are equal.
- R10: While `rst_n` is low, the line sits at `IDLE_LEVEL` and `cell_start`, `rx_done` and `rx_viol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A data bit is offered |
| in_ready | output | 1 | The encoder can take a bit at this edge |
| in_bit | input | 1 | Data bit |
| mode_diff | input | 1 | 0 = plain code, 1 = differential code |
| line_out | output | 1 | Encoded line level |
| cell_start | output | 1 | High during the first half of each cell |
| rx_line | input | 1 | Line level fed to the checker |
| rx_first | input | 1 | Marks the checker's first-half sample |
| rx_bit | output | 1 | First-half level of the last checked cell |
| rx_done | output | 1 | One-cycle pulse when a cell has been checked |
| rx_viol | output | 1 | Last checked cell had no mid-cell change |

## Verification
Two events can land on the same edge:
- **Cell end and the next transfer.** A bit can transfer on the very edge where the previous cell ends, and a mode change can be presented at that same edge. The table-driven run streams bits back to back while changing modes, so every new cell starts on the ending edge of the one before. Each half-cell level is judged against an in-bench model of the code rules.
- **Mid-cell mode change while a new bit waits.** A directed case flips `mode_diff` and `in_bit` inside a plain cell while `in_valid` stays high. The test checks that the cell still finishes under the old rules and that the waiting bit is then encoded differentially from a falling reference.

The checker runs on the encoder's own line during the stream and is then fed a line that stays flat across a cell.

// File: rtl/mle_pkg.sv
package mle_pkg;
  typedef enum logic {
    MODE_PLAIN = 1'b0,
    MODE_DIFF  = 1'b1
  } line_mode_e;

  // Level of the first half-cell for a given data bit, mode and last centre edge.
  function automatic logic first_half_level(input logic din, input line_mode_e md,
                                            input logic last_fall);
    logic fall_now;
    if (md == MODE_DIFF) fall_now = last_fall ^ din;
    else                 fall_now = din;
    return fall_now; // a falling centre starts high
  endfunction
endpackage

// File: rtl/mle_cell_seq.sv
module mle_cell_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic take,
  output logic first_half,
  output logic active
);
  assign in_ready = ~first_half;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_half <= 1'b0;
      active     <= 1'b0;
    end else if (take) begin
      first_half <= 1'b1;
      active     <= 1'b1;
    end else if (first_half) begin
      first_half <= 1'b0;
    end else begin
      active <= 1'b0;
    end
  end

  p_cell_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (first_half && active));
  p_first_half_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    first_half |=> !first_half);
  p_ready_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    first_half |-> !in_ready);
endmodule

// File: rtl/mle_level_gen.sv
module mle_level_gen
  import mle_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic din,
  input  logic mode_diff,
  input  logic first_half,
  input  logic active,
  output logic line_q
);
  logic       last_fall;
  logic       pre_lvl;
  line_mode_e md;

  assign md      = line_mode_e'(mode_diff);
  assign pre_lvl = first_half_level(din, md, last_fall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q    <= IDLE_LEVEL;
      last_fall <= 1'b1;
    end else if (take) begin
      line_q    <= pre_lvl;
      last_fall <= pre_lvl;
    end else if (first_half) begin
      line_q <= ~line_q;
    end else begin
      line_q <= IDLE_LEVEL;
    end
  end

  p_centre_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !first_half) |-> (line_q != $past(line_q)));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (line_q == IDLE_LEVEL));
endmodule

// File: rtl/mle_cell_check.sv
module mle_cell_check (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic rx_first,
  output logic rx_bit,
  output logic rx_done,
  output logic rx_viol
);
  logic half1;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half1   <= 1'b0;
      armed   <= 1'b0;
      rx_bit  <= 1'b0;
      rx_done <= 1'b0;
      rx_viol <= 1'b0;
    end else if (rx_first) begin
      half1   <= rx_line;
      armed   <= 1'b1;
      rx_done <= 1'b0;
    end else if (armed) begin
      armed   <= 1'b0;
      rx_done <= 1'b1;
      rx_bit  <= half1;
      rx_viol <= (rx_line == half1);
    end else begin
      rx_done <= 1'b0;
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  p_done_after_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(rx_first, 2));
endmodule

// File: rtl/manchester_line_enc.sv
module manchester_line_enc #(
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic mode_diff,
  output logic line_out,
  output logic cell_start,
  input  logic rx_line,
  input  logic rx_first,
  output logic rx_bit,
  output logic rx_done,
  output logic rx_viol
);
  logic take;
  logic first_half;
  logic active;

  mle_cell_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .take      (take),
    .first_half(first_half),
    .active    (active)
  );

  mle_level_gen #(.IDLE_LEVEL(IDLE_LEVEL)) u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .din       (in_bit),
    .mode_diff (mode_diff),
    .first_half(first_half),
    .active    (active),
    .line_q    (line_out)
  );

  mle_cell_check u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_line (rx_line),
    .rx_first(rx_first),
    .rx_bit  (rx_bit),
    .rx_done (rx_done),
    .rx_viol (rx_viol)
  );

  assign cell_start = first_half;

  p_marker_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (!cell_start && (line_out == IDLE_LEVEL)));
endmodule

// File: tb/sim_manchester_line_enc.sv
module sim_manchester_line_enc;
  localparam int CLK_P = 10;
  localparam logic IDLE = 1'b0;
  localparam int NV = 12;
  // {mode, bit}
  localparam logic [1:0] VEC [0:NV-1] = '{2'b01, 2'b00, 2'b01, 2'b11, 2'b11, 2'b10,
                                          2'b11, 2'b10, 2'b10, 2'b01, 2'b11, 2'b00};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, mode_diff = 1'b0;
  logic in_ready, line_out, cell_start, rx_bit, rx_done, rx_viol;
  logic man = 1'b0, man_line = 1'b0, man_first = 1'b0;
  logic rx_line, rx_first;
  int tests = 0, fails = 0;
  logic model_fall;
  logic exp_pre, prev_pre;

  assign rx_line  = man ? man_line  : line_out;
  assign rx_first = man ? man_first : cell_start;

  always #(CLK_P/2) clk = ~clk;

  manchester_line_enc #(.IDLE_LEVEL(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .mode_diff(mode_diff), .line_out(line_out),
    .cell_start(cell_start), .rx_line(rx_line), .rx_first(rx_first),
    .rx_bit(rx_bit), .rx_done(rx_done), .rx_viol(rx_viol));

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic pre_of(input logic md, input logic b, input logic lf);
    return md ? (lf ^ b) : b;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 line idle", line_out, IDLE);
    chk("R10 cell_start", cell_start, 1'b0);
    chk("R10 rx_done", rx_done, 1'b0);
    chk("R10 rx_viol", rx_viol, 1'b0);
    rst_n = 1'b1;
    model_fall = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R5 ready when idle", in_ready, 1'b1);

    // Table walk: back-to-back cells with mode changes on cell boundaries.
    prev_pre = 1'b0;
    for (int v = 0; v < NV; v++) begin
      in_valid  = 1'b1;
      mode_diff = VEC[v][1];
      in_bit    = VEC[v][0];
      exp_pre   = pre_of(VEC[v][1], VEC[v][0], model_fall);
      model_fall = exp_pre;
      chk("R5 ready at boundary", in_ready, 1'b1);
      @(negedge clk);
      chk(VEC[v][1] ? "R3 first half" : (VEC[v][0] ? "R1 first half" : "R2 first half"),
          line_out, exp_pre);
      chk("R7 marker first half", cell_start, 1'b1);
      chk("R5 not ready first half", in_ready, 1'b0);
      if (v > 0) begin
        chk("R9 loop done", rx_done, 1'b1);
        chk("R9 loop no violation", rx_viol, 1'b0);
        chk("R9 loop bit", rx_bit, prev_pre);
      end
      @(negedge clk);
      chk(VEC[v][1] ? "R3 second half" : (VEC[v][0] ? "R1 second half" : "R2 second half"),
          line_out, ~exp_pre);
      chk("R7 marker second half", cell_start, 1'b0);
      prev_pre = exp_pre;
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 idle after stream", line_out, IDLE);
    chk("R9 last cell done", rx_done, 1'b1);
    @(negedge clk);
    chk("R8 idle holds", line_out, IDLE);

    // Mid-cell mode change with a waiting bit.
    in_valid = 1'b1; mode_diff = 1'b0; in_bit = 1'b1;
    @(negedge clk);
    chk("R1 plain one high", line_out, 1'b1);
    mode_diff = 1'b1; in_bit = 1'b0;
    @(negedge clk);
    chk("R6 cell keeps plain code", line_out, 1'b0);
    @(negedge clk);
    chk("R3 diff zero after falling", line_out, 1'b1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R3 diff zero second half", line_out, 1'b0);

    // Differential reference after reset.
    do_reset();
    in_valid = 1'b1; mode_diff = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    chk("R4 diff one after reset first half", line_out, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R4 diff one after reset second half", line_out, 1'b1);

    // Checker driven by hand.
    man = 1'b1;
    man_first = 1'b1; man_line = 1'b1;
    @(negedge clk);
    man_first = 1'b0; man_line = 1'b1;
    @(negedge clk);
    chk("R9 flat cell done", rx_done, 1'b1);
    chk("R9 flat cell violation", rx_viol, 1'b1);
    man_first = 1'b1; man_line = 1'b0;
    @(negedge clk);
    chk("R9 done is a pulse", rx_done, 1'b0);
    man_first = 1'b0; man_line = 1'b1;
    @(negedge clk);
    chk("R9 good cell no violation", rx_viol, 1'b0);
    chk("R9 good cell bit", rx_bit, 1'b0);
    man = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule